// File: doc/BRIEF.md
# Packed-Write Colour Palette Loader

This block keeps a 256-entry table of red/green/blue colours. A host loads it through two write strobes. One strobe sets the entry pointer. The other delivers a 32-bit data word. The table itself accepts one 8-bit colour component per clock. Each data word is therefore broken into bytes, and each byte fills the next component of the current entry. Within an entry the components go red first, then green, then blue. After blue the pointer moves to the following entry.

A mode input picks how a data word is consumed. In packed mode all four bytes of a word are used, most significant byte first, so a single word can finish one entry and start the next. In narrow mode only the top byte counts, and each word delivers one component. The component phase is kept between words, whatever the mode.

A separate display index reads any entry combinationally as a 24-bit {R,G,B} value, for use by the pixel pipeline.

Top module: `palette_loader`

## Requirements
- R1: After reset `busy` is 0, the pointer is entry 0 at the red phase, and every entry reads 24'h000000.
- R2: An accepted address write (`addr_we` high while `busy` is low) sets the pointer to `addr_in` and restarts the phase at red. If `data_we` is high in the same cycle, the data word is ignored.
- R3: Components are stored in the order red, green, blue. The pointer advances by one only after a blue component has been stored.
- R4: In packed mode (`narrow_mode`=0), an accepted data word delivers four components: bits 31:24 first, then 23:16, then 15:8, and bits 7:0 last. After address 0, the words 32'h11223344 and 32'h55667788 give entry 0 = 112233, entry 1 = 445566 and entry 2 = 7788xx.
- R5: In narrow mode (`narrow_mode`=1), an accepted data word delivers exactly one component, taken from bits 31:24. Bits 23:0 are ignored and `busy` stays low.
- R6: Components that are not delivered keep their old values. One packed word at address 0 replaces only the red of entry 1.
- R7: The pointer wraps from entry 255 to entry 0 when it advances.
- R8: An accepted packed word stores its first component at the accepting edge. `busy` is then high for exactly 3 cycles while the other three components are stored. Data writes and address writes presented while `busy` is high are ignored.
- R9: The component phase carries across data words and across mode changes between words.
- R10: `disp_rgb` is {red[23:16], green[15:8], blue[7:0]} of the entry selected by `disp_idx`, in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Address write strobe |
| addr_in | input | 8 | Entry index to load into the pointer |
| data_we | input | 1 | Data write strobe |
| data_in | input | 32 | Data word carrying packed colour bytes |
| narrow_mode | input | 1 | 1: top byte only; 0: all four bytes |
| busy | output | 1 | High while a packed word is still unloading |
| disp_idx | input | 8 | Display lookup index |
| disp_rgb | output | 24 | {R,G,B} of entry `disp_idx` |

## Verification
A component sampled at a clock edge is visible on `disp_rgb` right after that edge, through a single register stage. A packed word therefore completes on the third edge after the accepting edge, and `busy` falls on that same edge. The bench's reference model advances once per rising edge, with the same one-component-per-edge rule. It compares `busy` and `disp_rgb` 3 ns after each edge, once the design has settled and before the inputs change at the falling edge. Directed entry checks change only `disp_idx` at a falling edge and sample 1 ns later, so the read path is tested with no clock edge in between.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // Component that follows p within one entry.
  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  // True when storing component p finishes an entry.
  function automatic logic ends_entry(phase_e p);
    return p == PH_BLU;
  endfunction

endpackage

// File: rtl/palette_word_unpacker.sv
module palette_word_unpacker #(
  parameter int COMP_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic                         narrow,
  input  logic [COMP_W*WORD_BYTES-1:0] word,
  output logic                         busy,
  output logic                         emit_valid,
  output logic [COMP_W-1:0]            emit_byte
);
  localparam int WORD_W = COMP_W * WORD_BYTES;
  localparam int REM_W  = COMP_W * (WORD_BYTES - 1);
  localparam int CNT_W  = $clog2(WORD_BYTES);

  logic [REM_W-1:0] rem_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      left_q <= '0;
    end else if (accept && !narrow) begin
      rem_q  <= word[REM_W-1:0];
      left_q <= CNT_W'(WORD_BYTES - 1);
    end else if (left_q != '0) begin
      rem_q  <= rem_q << COMP_W;
      left_q <= left_q - 1'b1;
    end
  end

  assign busy       = (left_q != '0);
  assign emit_valid = accept | busy;
  assign emit_byte  = busy ? rem_q[REM_W-1 -: COMP_W] : word[WORD_W-1 -: COMP_W];
endmodule

// File: rtl/palette_sequencer.sv
module palette_sequencer
  import palette_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ptr,
  input  logic [IDX_W-1:0] ptr_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase,
  output logic             wrap_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (set_ptr) begin
      idx   <= ptr_val;
      phase <= PH_RED;
    end else if (step) begin
      phase <= phase_after(phase);
      if (ends_entry(phase)) idx <= idx + 1'b1;
    end
  end

  assign wrap_evt = step && ends_entry(phase) && (idx == '1);
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  phase_e              wr_phase,
  input  logic [COMP_W-1:0]   wr_byte,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [3*COMP_W-1:0] rd_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COMP_W-1:0] rd_part [3];

  for (genvar c = 0; c < 3; c++) begin : g_plane
    logic [COMP_W-1:0] plane [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) plane[i] <= '0;
      end else if (wr_en && (wr_phase == phase_e'(c))) begin
        plane[wr_idx] <= wr_byte;
      end
    end

    assign rd_part[c] = plane[rd_idx];
  end

  assign rd_rgb = {rd_part[0], rd_part[1], rd_part[2]};
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import palette_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int COMP_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         addr_we,
  input  logic [IDX_W-1:0]             addr_in,
  input  logic                         data_we,
  input  logic [COMP_W*WORD_BYTES-1:0] data_in,
  input  logic                         narrow_mode,
  output logic                         busy,
  input  logic [IDX_W-1:0]             disp_idx,
  output logic [3*COMP_W-1:0]          disp_rgb
);
  // Internal events, brought out by name for the checker.
  logic              addr_take;
  logic              data_take;
  logic              commit_en;
  logic [COMP_W-1:0] commit_byte;
  logic [IDX_W-1:0]  cur_idx;
  phase_e            cur_phase;
  logic              wrap_evt;

  assign addr_take = addr_we && !busy;
  assign data_take = data_we && !busy && !addr_we;

  palette_word_unpacker #(.COMP_W(COMP_W), .WORD_BYTES(WORD_BYTES)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (data_take),
    .narrow     (narrow_mode),
    .word       (data_in),
    .busy       (busy),
    .emit_valid (commit_en),
    .emit_byte  (commit_byte)
  );

  palette_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ptr  (addr_take),
    .ptr_val  (addr_in),
    .step     (commit_en),
    .idx      (cur_idx),
    .phase    (cur_phase),
    .wrap_evt (wrap_evt)
  );

  palette_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_en),
    .wr_idx   (cur_idx),
    .wr_phase (cur_phase),
    .wr_byte  (commit_byte),
    .rd_idx   (disp_idx),
    .rd_rgb   (disp_rgb)
  );
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk
  import palette_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_we,
  input logic [IDX_W-1:0] addr_in,
  input logic             data_we,
  input logic             narrow_mode,
  input logic             busy,
  input logic             commit_en,
  input logic [IDX_W-1:0] commit_idx,
  input phase_e           commit_phase,
  input logic             wrap_evt
);
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !busy) |=> (commit_idx == $past(addr_in) && commit_phase == PH_RED));

  p_addr_blocks_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !busy) |-> !commit_en);

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_phase != phase_e'(2'd3));

  p_blue_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && commit_phase == PH_BLU) |=> commit_idx == $past(commit_idx) + 1'b1);

  p_hold_mid_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && commit_phase != PH_BLU) |=> $stable(commit_idx));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> commit_idx == '0);

  p_narrow_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && !busy && narrow_mode) |=> !busy);

  p_packed_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !addr_we && !busy && !narrow_mode) |=> busy);

  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == 8'(WORD_BYTES - 1));

  p_busy_commits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> commit_en);
endmodule

bind palette_loader palette_loader_chk #(.IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_we      (addr_we),
  .addr_in      (addr_in),
  .data_we      (data_we),
  .narrow_mode  (narrow_mode),
  .busy         (busy),
  .commit_en    (commit_en),
  .commit_idx   (cur_idx),
  .commit_phase (cur_phase),
  .wrap_evt     (wrap_evt)
);

// File: tb/palette_loader_test.sv
`timescale 1ns/1ps
module palette_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_we = 1'b0;
  logic [7:0]  addr_in = '0;
  logic        data_we = 1'b0;
  logic [31:0] data_in = '0;
  logic        narrow_mode = 1'b0;
  logic        busy;
  logic [7:0]  disp_idx = '0;
  logic [23:0] disp_rgb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  palette_loader uut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_in(addr_in),
    .data_we(data_we), .data_in(data_in), .narrow_mode(narrow_mode),
    .busy(busy), .disp_idx(disp_idx), .disp_rgb(disp_rgb)
  );

  // Behavioural reference: colour arrays, pointer, phase, byte queue.
  logic [7:0] ref_col [3][256];
  int         ref_ptr;
  int         ref_ph;
  logic [7:0] pend [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 256; e++)
        for (int c = 0; c < 3; c++) ref_col[c][e] = 8'h00;
      ref_ptr = 0;
      ref_ph  = 0;
      pend.delete();
    end else begin
      if (pend.size() == 0) begin
        if (addr_we) begin
          ref_ptr = addr_in;
          ref_ph  = 0;
        end else if (data_we) begin
          if (narrow_mode) pend.push_back(data_in[31:24]);
          else for (int k = 3; k >= 0; k--) pend.push_back(data_in[8*k +: 8]);
        end
      end
      if (pend.size() != 0) begin
        ref_col[ref_ph][ref_ptr] = pend.pop_front();
        if (ref_ph == 2) begin
          ref_ph  = 0;
          ref_ptr = (ref_ptr + 1) % 256;
        end else begin
          ref_ph = ref_ph + 1;
        end
      end
    end
    #3;
    if (rst_n) begin
      checks++;
      if (busy !== (pend.size() != 0)) begin
        errors++;
        $display("FAIL R8 busy got %0b exp %0b", busy, pend.size() != 0);
      end
      checks++;
      if (disp_rgb !== {ref_col[0][disp_idx], ref_col[1][disp_idx], ref_col[2][disp_idx]}) begin
        errors++;
        $display("FAIL R10 rgb idx %0d got %h exp %h", disp_idx, disp_rgb,
                 {ref_col[0][disp_idx], ref_col[1][disp_idx], ref_col[2][disp_idx]});
      end
    end
  end

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk); addr_we = 1'b1; addr_in = a;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic put_word(input logic [31:0] w, input logic nar);
    @(negedge clk); data_we = 1'b1; data_in = w; narrow_mode = nar;
    @(negedge clk); data_we = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic check_entry(input logic [7:0] i, input logic [23:0] exp, input string tag);
    @(negedge clk); disp_idx = i; #1;
    checks++;
    if (disp_rgb !== exp) begin
      errors++;
      $display("FAIL %s entry %0d got %h exp %h", tag, i, disp_rgb, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin errors++; $display("FAIL R1 busy got %0b exp 0", busy); end
    check_entry(8'd0,   24'h000000, "R1");
    check_entry(8'd255, 24'h000000, "R1");

    // R3/R5: narrow triple into entry 1, low bytes ignored
    set_addr(8'd1);
    put_word(32'hAA123456, 1'b1);
    checks++;
    if (busy !== 1'b0) begin errors++; $display("FAIL R5 busy got %0b exp 0", busy); end
    put_word(32'hBBFFFFFF, 1'b1);
    put_word(32'hCC000001, 1'b1);
    check_entry(8'd1, 24'hAABBCC, "R3");
    check_entry(8'd2, 24'h000000, "R5");

    // R6/R4: packed word at 0 touches only red of entry 1
    set_addr(8'd0);
    put_word(32'h11223344, 1'b0);
    check_entry(8'd1, 24'h44BBCC, "R6");
    put_word(32'h55667788, 1'b0);
    check_entry(8'd0, 24'h112233, "R4");
    check_entry(8'd1, 24'h445566, "R4");
    check_entry(8'd2, 24'h778800, "R4");

    // R9: narrow then packed, phase carries
    set_addr(8'd10);
    put_word(32'h99000000, 1'b1);
    put_word(32'hA1A2A3A4, 1'b0);
    check_entry(8'd10, 24'h99A1A2, "R9");
    check_entry(8'd11, 24'hA3A400, "R9");

    // R7: wrap from 255 to 0
    set_addr(8'd255);
    put_word(32'h01020304, 1'b0);
    put_word(32'h05060708, 1'b0);
    check_entry(8'd255, 24'h010203, "R7");
    check_entry(8'd0,   24'h040506, "R7");
    check_entry(8'd1,   24'h070866, "R7");

    // R8: writes during busy ignored, busy lasts 3 cycles
    set_addr(8'd20);
    @(negedge clk); data_we = 1'b1; data_in = 32'h10203040; narrow_mode = 1'b0;
    @(negedge clk); data_in = 32'hFFFFFFFF; addr_we = 1'b1; addr_in = 8'd50;
    @(negedge clk); data_we = 1'b0; addr_we = 1'b0;
    @(negedge clk);
    checks++;
    if (busy !== 1'b1) begin errors++; $display("FAIL R8 busy third cycle got %0b exp 1", busy); end
    @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin errors++; $display("FAIL R8 busy after got %0b exp 0", busy); end
    put_word(32'h5A000000, 1'b1);
    check_entry(8'd20, 24'h102030, "R8");
    check_entry(8'd21, 24'h405A00, "R8");
    check_entry(8'd50, 24'h000000, "R8");

    // R2: address and data together, data dropped; re-addressing restarts red
    @(negedge clk); addr_we = 1'b1; addr_in = 8'd30; data_we = 1'b1; data_in = 32'h77777777;
    @(negedge clk); addr_we = 1'b0; data_we = 1'b0;
    put_word(32'h12000000, 1'b1);
    check_entry(8'd30, 24'h120000, "R2");
    set_addr(8'd40);
    put_word(32'h61000000, 1'b1);
    set_addr(8'd40);
    put_word(32'h62000000, 1'b1);
    put_word(32'h63000000, 1'b1);
    check_entry(8'd40, 24'h626300, "R2");

    // R10: sweep the read port over several entries
    for (int j = 0; j < 4; j++) check_entry(8'(j), {ref_col[0][j], ref_col[1][j], ref_col[2][j]}, "R10");

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule